// File: doc/BRIEF.md
# Two-Colour Hardware Cursor Line Renderer

This block renders one scanline of a 64x64 two-colour hardware cursor that is laid over the display. A scanline begins with a pulse on `line_start`. The block then decides whether the current scan row falls inside the cursor's vertical window. If it does, the block reads that cursor row's 16 bytes from video memory, one byte request at a time. It then streams out one pixel per cycle. Each pixel carries its screen X position, a 32-bit ARGB colour and the mask bit for that position.

The fetch address accounts for a packed hotspot register. The upper half of that register moves the image base back by whole bytes. The lower half moves it back by whole 16-byte rows. Pixels stop at the right edge of the visible area, so the cursor never spills onto the next display line. A downstream compositor uses the mask bit for any transparency or inversion handling.

Top module: `hw_cursor_line`

## Requirements
- R1: After reset, and until the first `line_start`, `mem_req`, `px_valid` and `line_done` are all 0.
- R2: A scanline is inside the window when `cur_y <= scan_y <= cur_y + 63`. A scanline outside the window issues no memory request and no pixel, and it still ends with a `line_done` pulse.
- R3: An in-window line issues exactly 16 byte reads, at addresses `line_base + k` for k = 0 to 15 in ascending order, taken modulo 2^ADDR_W. Each address and `mem_req` are held until the `mem_rvalid` that answers them. `line_base` is the effective base plus `(scan_y - cur_y) * 16`.
- R4: The effective base is `cur_base - hotspot[31:16] - hotspot[15:0] * 16`, modulo 2^ADDR_W.
- R5: All 16 reads complete before the first pixel appears. Pixels then come on consecutive cycles, with `px_x = cur_x + i` for pixel index i = 0, 1, 2 and so on.
- R6: The fetched bytes 0 to 7 form the mask plane and bytes 8 to 15 form the colour plane. Pixel i takes bit `7 - (i mod 8)` of byte `i / 8` of each plane, most significant bit first. The mask bit is output on `px_mask`.
- R7: A colour-plane bit of 1 outputs `color1` and a bit of 0 outputs `color0`. The result appears in `px_argb[23:0]`, and `px_argb[31:24]` is always 8'hFF.
- R8: The visible width is `(htotal_disp[26:16] + 1) * 8` pixels. A pixel whose X is at or beyond the visible width is not output, and the line ends at the first such pixel. If `cur_x` is already at or past the width, the line outputs no pixels, but its 16 reads still take place.
- R9: `line_done` pulses for one cycle after the last pixel, or after the reads when no pixel is output. During that cycle `px_valid` and `mem_req` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_start | input | 1 | Begin a scanline (accepted when idle) |
| scan_y | input | Y_W | Current scan row |
| cur_x | input | X_W | Cursor left edge on screen |
| cur_y | input | Y_W | Cursor top row on screen |
| cur_base | input | ADDR_W | Cursor image base address |
| hotspot | input | 32 | Packed offset: [31:16] bytes, [15:0] rows of 16 bytes |
| color0 | input | 24 | RGB used for colour-plane bit 0 |
| color1 | input | 24 | RGB used for colour-plane bit 1 |
| htotal_disp | input | 32 | Horizontal timing word; [26:16] is the display width in 8-pixel units minus 1 |
| mem_req | output | 1 | Byte read request, held until answered |
| mem_addr | output | ADDR_W | Byte address of the request |
| mem_rvalid | input | 1 | One-cycle response strobe |
| mem_rdata | input | 8 | Response byte |
| px_valid | output | 1 | Pixel output valid |
| px_x | output | X_W | Pixel screen X |
| px_argb | output | 32 | Pixel colour, alpha in [31:24] |
| px_mask | output | 1 | Mask-plane bit of the pixel |
| line_done | output | 1 | End-of-line pulse |

## Verification
The bench tries a plain mid-window row with no hotspot offset, which sets the basic address arithmetic and the MSB-first bit order against a byte pattern derived from each address. It also tries a nonzero hotspot offset and a base small enough that the subtraction wraps below zero, which separates the two hotspot halves and their scaling, as well as the modulo behaviour. The first and last rows of the window are tried together with the rows just outside it, which exposes off-by-one errors in the window test. Finally, the visible width is narrowed so that the cursor is cut partway through, or starts beyond the edge, which checks where emission stops and that the reads still happen.

// File: rtl/hwc_pkg.sv
package hwc_pkg;

  typedef enum logic [1:0] {
    HWC_IDLE,
    HWC_FETCH,
    HWC_EMIT,
    HWC_FIN
  } hwc_state_e;

  // Image base moved back by the hotspot: upper half in bytes, lower half in 16-byte rows
  function automatic logic [31:0] hwc_eff_base(input logic [31:0] base,
                                               input logic [31:0] hot);
    logic [31:0] byte_back;
    logic [31:0] row_back;
    byte_back = {16'h0000, hot[31:16]};
    row_back  = {12'h000, hot[15:0], 4'h0};
    return base - byte_back - row_back;
  endfunction

  // First byte of the cursor row that the scan row hits
  function automatic logic [31:0] hwc_line_addr(input logic [31:0] eff,
                                                input logic [31:0] row,
                                                input logic [31:0] pitch);
    return eff + row * pitch;
  endfunction

  // Visible pixels on a line, from the display-width field in 8-pixel units
  function automatic logic [15:0] hwc_vis_width(input logic [31:0] htd);
    return ({5'h00, htd[26:16]} + 16'd1) << 3;
  endfunction

  // Pixel pos within a byte, most significant bit first
  function automatic logic hwc_msb_first(input logic [7:0] b, input logic [2:0] pos);
    return b[3'd7 - pos];
  endfunction

endpackage

// File: rtl/hwc_addr_gen.sv
module hwc_addr_gen
  import hwc_pkg::*;
#(
  parameter int ADDR_W = 27,
  parameter int Y_W    = 12,
  parameter int CUR_H  = 64,
  parameter int PITCH  = 16
) (
  input  logic [Y_W-1:0]    scan_y,
  input  logic [Y_W-1:0]    cur_y,
  input  logic [ADDR_W-1:0] cur_base,
  input  logic [31:0]       hotspot,
  output logic              in_window,
  output logic [ADDR_W-1:0] line_addr
);

  logic [Y_W:0]  row_diff;
  logic [31:0]   eff_base;
  logic [31:0]   row_ext;
  logic [31:0]   line_full;

  always_comb begin
    row_diff  = {1'b0, scan_y} - {1'b0, cur_y};
    // negative difference sets the top bit: row above the cursor
    in_window = !row_diff[Y_W] && (32'(row_diff[Y_W-1:0]) < 32'(CUR_H));
    row_ext   = 32'(row_diff[Y_W-1:0]);
    eff_base  = hwc_eff_base(32'(cur_base), hotspot);
    line_full = hwc_line_addr(eff_base, row_ext, 32'(PITCH));
    line_addr = line_full[ADDR_W-1:0];
  end

endmodule

// File: rtl/hwc_line_buf.sv
module hwc_line_buf #(
  parameter int NBYTES = 16,
  parameter int IDX_W  = $clog2(NBYTES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [7:0]            wr_data,
  output logic [NBYTES*8-1:0]   planes
);

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    logic [7:0] byte_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        byte_q <= 8'h00;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        byte_q <= wr_data;
      end
    end
    assign planes[g*8 +: 8] = byte_q;
  end

endmodule

// File: rtl/hwc_pix_sel.sv
module hwc_pix_sel
  import hwc_pkg::*;
#(
  parameter int CUR_W = 64,
  parameter int PLANE_BYTES = CUR_W / 8,
  parameter int PI_W = $clog2(CUR_W)
) (
  input  logic [2*PLANE_BYTES*8-1:0] planes,
  input  logic [PI_W-1:0]            pix_idx,
  input  logic [23:0]                color0,
  input  logic [23:0]                color1,
  output logic                       mask_bit,
  output logic [31:0]                argb
);

  localparam int BSEL_W = PI_W - 3;

  logic [BSEL_W-1:0] byte_sel;
  logic [2:0]        bit_pos;
  logic [7:0]        mask_byte;
  logic [7:0]        col_byte;
  logic              col_bit;

  always_comb begin
    byte_sel  = pix_idx[PI_W-1:3];
    bit_pos   = pix_idx[2:0];
    mask_byte = planes[32'(byte_sel) * 8 +: 8];
    col_byte  = planes[(32'(byte_sel) + PLANE_BYTES) * 8 +: 8];
    mask_bit  = hwc_msb_first(mask_byte, bit_pos);
    col_bit   = hwc_msb_first(col_byte, bit_pos);
    argb      = {8'hFF, (col_bit ? color1 : color0)};
  end

endmodule

// File: rtl/hw_cursor_line.sv
module hw_cursor_line
  import hwc_pkg::*;
#(
  parameter int ADDR_W = 27,
  parameter int Y_W    = 12,
  parameter int X_W    = 14,
  parameter int CUR_W  = 64,
  parameter int CUR_H  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start,
  input  logic [Y_W-1:0]    scan_y,
  input  logic [X_W-1:0]    cur_x,
  input  logic [Y_W-1:0]    cur_y,
  input  logic [ADDR_W-1:0] cur_base,
  input  logic [31:0]       hotspot,
  input  logic [23:0]       color0,
  input  logic [23:0]       color1,
  input  logic [31:0]       htotal_disp,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [7:0]        mem_rdata,
  output logic              px_valid,
  output logic [X_W-1:0]    px_x,
  output logic [31:0]       px_argb,
  output logic              px_mask,
  output logic              line_done
);

  localparam int PLANE_BYTES = CUR_W / 8;
  localparam int PITCH       = 2 * PLANE_BYTES;
  localparam int BI_W        = $clog2(PITCH);
  localparam int PI_W        = $clog2(CUR_W);
  localparam int WW          = X_W + 2;

  hwc_state_e            state_q;
  logic                  in_window;
  logic [ADDR_W-1:0]     line_addr;
  logic [ADDR_W-1:0]     line_addr_q;
  logic [X_W-1:0]        x0_q;
  logic [23:0]           c0_q;
  logic [23:0]           c1_q;
  logic [WW-1:0]         width_q;
  logic [BI_W-1:0]       byte_idx_q;
  logic [PI_W-1:0]       pix_idx_q;
  logic [PITCH*8-1:0]    planes;
  logic                  sel_mask;
  logic [31:0]           sel_argb;

  // named events for the checker
  logic                  st_idle;
  logic                  byte_arrive;
  logic                  fetch_last;
  logic [WW-1:0]         cand_x;
  logic                  emit_stop;
  logic                  pix_last;

  assign st_idle     = (state_q == HWC_IDLE);
  assign byte_arrive = (state_q == HWC_FETCH) && mem_rvalid;
  assign fetch_last  = byte_arrive && (byte_idx_q == BI_W'(PITCH - 1));
  assign cand_x      = WW'(x0_q) + WW'(pix_idx_q);
  assign emit_stop   = (cand_x >= width_q);
  assign pix_last    = (pix_idx_q == PI_W'(CUR_W - 1));

  assign mem_req  = (state_q == HWC_FETCH);
  assign mem_addr = line_addr_q + ADDR_W'(byte_idx_q);

  hwc_addr_gen #(
    .ADDR_W (ADDR_W),
    .Y_W    (Y_W),
    .CUR_H  (CUR_H),
    .PITCH  (PITCH)
  ) u_addr (
    .scan_y    (scan_y),
    .cur_y     (cur_y),
    .cur_base  (cur_base),
    .hotspot   (hotspot),
    .in_window (in_window),
    .line_addr (line_addr)
  );

  hwc_line_buf #(
    .NBYTES (PITCH)
  ) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (byte_arrive),
    .wr_idx  (byte_idx_q),
    .wr_data (mem_rdata),
    .planes  (planes)
  );

  hwc_pix_sel #(
    .CUR_W (CUR_W)
  ) u_sel (
    .planes   (planes),
    .pix_idx  (pix_idx_q),
    .color0   (c0_q),
    .color1   (c1_q),
    .mask_bit (sel_mask),
    .argb     (sel_argb)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= HWC_IDLE;
      line_addr_q <= '0;
      x0_q        <= '0;
      c0_q        <= '0;
      c1_q        <= '0;
      width_q     <= '0;
      byte_idx_q  <= '0;
      pix_idx_q   <= '0;
      px_valid    <= 1'b0;
      px_x        <= '0;
      px_argb     <= '0;
      px_mask     <= 1'b0;
      line_done   <= 1'b0;
    end else begin
      px_valid  <= 1'b0;
      line_done <= 1'b0;
      unique case (state_q)
        HWC_IDLE: begin
          if (line_start) begin
            line_addr_q <= line_addr;
            x0_q        <= cur_x;
            c0_q        <= color0;
            c1_q        <= color1;
            width_q     <= WW'(hwc_vis_width(htotal_disp));
            byte_idx_q  <= '0;
            pix_idx_q   <= '0;
            state_q     <= in_window ? HWC_FETCH : HWC_FIN;
          end
        end
        HWC_FETCH: begin
          if (fetch_last) begin
            state_q <= HWC_EMIT;
          end else if (byte_arrive) begin
            byte_idx_q <= byte_idx_q + BI_W'(1);
          end
        end
        HWC_EMIT: begin
          if (emit_stop) begin
            state_q <= HWC_FIN;
          end else begin
            px_valid <= 1'b1;
            px_x     <= cand_x[X_W-1:0];
            px_argb  <= sel_argb;
            px_mask  <= sel_mask;
            if (pix_last) begin
              state_q <= HWC_FIN;
            end else begin
              pix_idx_q <= pix_idx_q + PI_W'(1);
            end
          end
        end
        HWC_FIN: begin
          line_done <= 1'b1;
          state_q   <= HWC_IDLE;
        end
        default: state_q <= HWC_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/hwc_checker.sv
module hwc_checker #(
  parameter int ADDR_W = 27,
  parameter int X_W    = 14,
  parameter int WW     = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              line_start,
  input logic              st_idle,
  input logic              in_window,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rvalid,
  input logic              px_valid,
  input logic [X_W-1:0]    px_x,
  input logic [31:0]       px_argb,
  input logic              line_done,
  input logic [WW-1:0]     width_q
);

  // R2: a row outside the window never starts a read
  p_no_fetch_outside_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && st_idle && !in_window) |=> !mem_req);

  // R3: an unanswered request keeps its address
  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

  // R5: reads and pixels never overlap
  p_fetch_before_pix_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(px_valid && mem_req));

  // R5: back-to-back pixels step X by one
  p_x_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (px_valid && $past(px_valid)) |-> (px_x == $past(px_x) + X_W'(1)));

  // R7: alpha is opaque
  p_alpha_r7: assert property (@(posedge clk) disable iff (!rst_n)
    px_valid |-> (px_argb[31:24] == 8'hFF));

  // R8: no pixel at or past the visible width
  p_in_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
    px_valid |-> (WW'(px_x) < width_q));

  // R9: end-of-line pulse is quiet and single
  p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |-> (!px_valid && !mem_req));
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |=> !line_done);

endmodule

bind hw_cursor_line hwc_checker #(
  .ADDR_W (ADDR_W),
  .X_W    (X_W),
  .WW     (WW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .line_start (line_start),
  .st_idle    (st_idle),
  .in_window  (in_window),
  .mem_req    (mem_req),
  .mem_addr   (mem_addr),
  .mem_rvalid (mem_rvalid),
  .px_valid   (px_valid),
  .px_x       (px_x),
  .px_argb    (px_argb),
  .line_done  (line_done),
  .width_q    (width_q)
);

// File: tb/hw_cursor_line_bench.sv
module hw_cursor_line_bench;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 27;
  localparam int Y_W = 12;
  localparam int X_W = 14;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              line_start = 1'b0;
  logic [Y_W-1:0]    scan_y = '0;
  logic [X_W-1:0]    cur_x = '0;
  logic [Y_W-1:0]    cur_y = '0;
  logic [ADDR_W-1:0] cur_base = '0;
  logic [31:0]       hotspot = '0;
  logic [23:0]       color0 = '0;
  logic [23:0]       color1 = '0;
  logic [31:0]       htotal_disp = '0;
  logic              mem_req;
  logic [ADDR_W-1:0] mem_addr;
  logic              mem_rvalid;
  logic [7:0]        mem_rdata;
  logic              px_valid;
  logic [X_W-1:0]    px_x;
  logic [31:0]       px_argb;
  logic              px_mask;
  logic              line_done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string cur_tag = "reset";

  logic [ADDR_W-1:0] exp_addr_q[$];
  logic [46:0]       exp_pix_q[$];

  hw_cursor_line u_hw_cursor_line (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] mem_byte(input logic [ADDR_W-1:0] a);
    return (a[7:0] * 8'd29) ^ a[15:8] ^ a[26:19] ^ 8'h5A;
  endfunction

  task automatic report_done();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // memory model: latency 1..3 cycles per byte, address checked at acceptance
  logic              mm_busy;
  logic [1:0]        mm_wait;
  logic [ADDR_W-1:0] mm_addr;
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_rvalid <= 1'b0;
      mem_rdata  <= 8'h00;
      mm_busy    <= 1'b0;
      mm_wait    <= 2'd0;
      mm_addr    <= '0;
    end else if (mem_rvalid) begin
      mem_rvalid <= 1'b0;
      mm_busy    <= 1'b0;
    end else if (mm_busy) begin
      if (mm_wait == 2'd0) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem_byte(mm_addr);
      end else begin
        mm_wait <= mm_wait - 2'd1;
      end
    end else if (mem_req) begin
      mm_busy <= 1'b1;
      mm_addr <= mem_addr;
      mm_wait <= 2'(mem_addr % 3);
      checks++;
      if (exp_addr_q.size() == 0) begin
        errors++;
        $display("FAIL R2/R3 [%s] unexpected read addr=%h expected none", cur_tag, mem_addr);
      end else begin
        logic [ADDR_W-1:0] ea;
        ea = exp_addr_q.pop_front();
        if (ea !== mem_addr) begin
          errors++;
          $display("FAIL R3/R4 [%s] read addr=%h expected %h", cur_tag, mem_addr, ea);
        end
      end
    end
  end

  // pixel monitor
  always @(negedge clk) begin
    if (rst_n && px_valid) begin
      checks++;
      if (exp_addr_q.size() != 0) begin
        errors++;
        $display("FAIL R5 [%s] pixel before reads done: pending=%0d expected 0",
                 cur_tag, exp_addr_q.size());
      end
      if (exp_pix_q.size() == 0) begin
        errors++;
        $display("FAIL R8 [%s] extra pixel x=%0d expected none", cur_tag, px_x);
      end else begin
        logic [46:0] e;
        e = exp_pix_q.pop_front();
        if ({px_x, px_argb, px_mask} !== e) begin
          errors++;
          $display("FAIL R5/R6/R7 [%s] got x=%0d argb=%h m=%b expected x=%0d argb=%h m=%b",
                   cur_tag, px_x, px_argb, px_mask, e[46:33], e[32:1], e[0]);
        end
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d expected finish", cycles);
      report_done();
    end
  end

  task automatic run_line(input int sy, input int cx, input int cy,
                          input logic [31:0] base, input logic [31:0] hv,
                          input logic [23:0] c0, input logic [23:0] c1,
                          input int wfield, input string tag);
    int row;
    int width;
    int waited;
    logic [31:0] start;
    logic [7:0] bytes [16];
    cur_tag = tag;
    row = sy - cy;
    width = (wfield + 1) * 8;
    if (row >= 0 && row < 64) begin
      start = base - (hv >> 16) - (hv & 32'h0000FFFF) * 16 + row * 16;
      for (int k = 0; k < 16; k++) begin
        logic [ADDR_W-1:0] a;
        a = ADDR_W'(start + k);
        exp_addr_q.push_back(a);
        bytes[k] = mem_byte(a);
      end
      for (int i = 0; i < 64; i++) begin
        logic mb;
        logic cb;
        if (cx + i >= width) break;
        mb = bytes[i / 8][7 - (i % 8)];
        cb = bytes[8 + i / 8][7 - (i % 8)];
        exp_pix_q.push_back({X_W'(cx + i), 8'hFF, (cb ? c1 : c0), mb});
      end
    end
    @(negedge clk);
    scan_y = Y_W'(sy);
    cur_x = X_W'(cx);
    cur_y = Y_W'(cy);
    cur_base = ADDR_W'(base);
    hotspot = hv;
    color0 = c0;
    color1 = c1;
    htotal_disp = {5'h00, 11'(wfield), 16'h1234};
    line_start = 1'b1;
    @(negedge clk);
    line_start = 1'b0;
    waited = 0;
    while (!line_done && waited < 3000) begin
      @(negedge clk);
      waited++;
    end
    checks++;
    if (!line_done) begin
      errors++;
      $display("FAIL R9 [%s] line_done=0 expected 1", tag);
    end else if (px_valid || mem_req) begin
      errors++;
      $display("FAIL R9 [%s] at done px_valid=%b mem_req=%b expected 0 0", tag, px_valid, mem_req);
    end
    checks++;
    if (exp_pix_q.size() != 0) begin
      errors++;
      $display("FAIL R8 [%s] missing pixels=%0d expected 0", tag, exp_pix_q.size());
    end
    checks++;
    if (exp_addr_q.size() != 0) begin
      errors++;
      $display("FAIL R3 [%s] missing reads=%0d expected 0", tag, exp_addr_q.size());
    end
    exp_pix_q.delete();
    exp_addr_q.delete();
    @(negedge clk);
    checks++;
    if (line_done) begin
      errors++;
      $display("FAIL R9 [%s] line_done held=1 expected 0", tag);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: quiet after reset
    checks++;
    if (mem_req || px_valid || line_done) begin
      errors++;
      $display("FAIL R1 req=%b valid=%b done=%b expected 0 0 0", mem_req, px_valid, line_done);
    end
    repeat (3) @(negedge clk);
    checks++;
    if (mem_req || px_valid || line_done) begin
      errors++;
      $display("FAIL R1 idle req=%b valid=%b done=%b expected 0 0 0", mem_req, px_valid, line_done);
    end
    // R3 R6 R7: plain row
    run_line(100, 16, 90, 32'h0000_1000, 32'h0, 24'h112233, 24'hAABBCC, 79, "R6 plain");
    // R4: hotspot with both halves
    run_line(200, 300, 200, 32'h0002_0000, {16'd3, 16'd2}, 24'h0000FF, 24'hFF0000, 79, "R4 hotspot");
    // R4: wrap below zero, last row of window (R2 boundary)
    run_line(163, 0, 100, 32'h0000_0005, {16'd7, 16'd1}, 24'h123456, 24'h654321, 99, "R4 wrap");
    // R2: first row of window at row zero
    run_line(0, 8, 0, 32'h0040_0000, 32'h0, 24'h00FF00, 24'h0F0F0F, 127, "R2 top");
    // R2: just below and just above window
    run_line(164, 0, 100, 32'h0000_3000, 32'h0, 24'h1, 24'h2, 79, "R2 below");
    run_line(99, 0, 100, 32'h0000_3000, 32'h0, 24'h1, 24'h2, 79, "R2 above");
    // R8: cursor cut at width 80
    run_line(50, 40, 20, 32'h0000_5550, 32'h0, 24'hABCDEF, 24'hFEDCBA, 9, "R8 clip");
    // R8: cursor starts at width edge
    run_line(50, 80, 20, 32'h0000_6660, 32'h0, 24'hABCDEF, 24'hFEDCBA, 9, "R8 offscreen");
    // R5: pattern at a high address
    run_line(1000, 1000, 980, 32'h07FF_FF00, {16'd16, 16'd0}, 24'hC0FFEE, 24'h0BADF0, 255, "R5 high");
    report_done();
  end

endmodule